// File: doc/BRIEF.md
# Per-Core Interrupt Line Router

This block gathers the interrupt requests of a small multi-core cluster and turns them into one normal-priority line (IRQ) and one fast line (FIQ) for each core. Each core has four timer request inputs and four mailbox-pending inputs of its own. On top of these there is one shared GPU request for each of the two line kinds, and one local-timer request. The timer counters and the mailbox storage sit outside the block; only their request levels arrive here.

Each core has two 8-bit control words, one for its timers and one for its mailboxes. Each control word gives every source an IRQ enable and an FIQ enable, and FIQ wins when both are set. Two routing words pick the core that receives the shared requests. The GPU IRQ and the GPU FIQ each have their own target core. The local timer has a target core and a line-kind choice. Software reads per-core pending words whose bits sit at fixed source positions. A word-wide register port with a one-cycle read latency gives access to all of this.

Top module: `irq_router`

## Requirements
- R1: After reset, every control and routing word reads as zero and all IRQ and FIQ outputs are low.
- R2: Timer control words sit at byte offset 0x40+4*core and mailbox control words at 0x50+4*core. A write stores only data bits 7:0, and a read returns them with bits 31:8 zero.
- R3: For a high timer input n (0..3) of a core whose timer control bit n is set and bit n+4 is clear, bit n of that core's IRQ pending word (0x60+4*core) is set and its FIQ pending word (0x70+4*core) bit n stays clear.
- R4: When both enable bits of an active source are set, the source appears only in the FIQ pending word and drives only the FIQ line.
- R5: When neither enable bit of an active source is set, the source appears in no pending word and raises no line.
- R6: Mailbox input n (0..3) of a core follows the same rule through the mailbox control word and lands in pending bit 4+n.
- R7: The GPU routing word at 0x0C keeps IRQ target core in bits 1:0 and FIQ target core in bits 3:2, reads back in the same positions, and the two GPU inputs set pending bit 8 of their own target cores.
- R8: The local-timer routing word at 0x24 keeps 3 bits: bits 1:0 give the core and bit 2 set selects FIQ instead of IRQ. The request sets pending bit 11 of that core.
- R9: A core's IRQ (FIQ) output is high exactly when its IRQ (FIQ) pending word is nonzero, one clock edge after the inputs or registers that cause it.
- R10: Writes to the pending words or to unmapped offsets change nothing. Reads of unmapped or misaligned offsets return zero.
- R11: Read data appears on the clock edge after the address is presented and holds until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | ADDR_W | Byte offset of the accessed word |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, registered |
| tmr_req | input | NCORES*4 | Timer request levels, core c input n at bit 4*c+n |
| mbx_pend | input | NCORES*4 | Mailbox pending levels, core c mailbox n at bit 4*c+n |
| gpu_irq | input | 1 | Shared GPU request for the IRQ line |
| gpu_fiq | input | 1 | Shared GPU request for the FIQ line |
| ltm_req | input | 1 | Local-timer request level |
| core_irq | output | NCORES | IRQ line per core |
| core_fiq | output | NCORES | FIQ line per core |

## Verification
Source levels steer into the pending words with no register in between, so an IRQ or FIQ output moves on the first clock edge after an input changes. After a register write it moves one edge later than that, because the control word itself is registered first. Read data lands on the edge after the address. The bench drives every stimulus just after a falling edge and samples at a later falling edge, counted by these delays. Some checks sample just before the due edge on purpose, to confirm that the earlier value still holds.

// File: rtl/irq_rt_pkg.sv
package irq_rt_pkg;
   localparam int PEND_W  = 12;
   localparam int SRC_GRP = 4;
   localparam int CTL_W   = 2 * SRC_GRP;

   localparam int BIT_TMR = 0;
   localparam int BIT_MBX = 4;
   localparam int BIT_GPU = 8;
   localparam int BIT_LTM = 11;

   localparam logic [3:0] GRP_GPU   = 4'h0;
   localparam logic [1:0] SLOT_GPU  = 2'd3;
   localparam logic [3:0] GRP_LTM   = 4'h2;
   localparam logic [1:0] SLOT_LTM  = 2'd1;
   localparam logic [3:0] GRP_TCTL  = 4'h4;
   localparam logic [3:0] GRP_MCTL  = 4'h5;
   localparam logic [3:0] GRP_IPEND = 4'h6;
   localparam logic [3:0] GRP_FPEND = 4'h7;

   typedef enum logic [1:0] {
      DST_NONE = 2'd0,
      DST_IRQ  = 2'd1,
      DST_FIQ  = 2'd2
   } dst_e;

   typedef struct packed {
      logic [1:0] gpu_fiq_core;
      logic [1:0] gpu_irq_core;
      logic       ltm_fiq;
      logic [1:0] ltm_core;
   } route_t;

   function automatic dst_e pick_dst(input logic active, input logic irq_en, input logic fiq_en);
      if (!active)
         return DST_NONE;
      else if (fiq_en)
         return DST_FIQ;
      else if (irq_en)
         return DST_IRQ;
      return DST_NONE;
   endfunction
endpackage

// File: rtl/irq_rt_steer.sv
module irq_rt_steer
   import irq_rt_pkg::*;
(
   input  logic [CTL_W-1:0]   tmr_ctl,
   input  logic [CTL_W-1:0]   mbx_ctl,
   input  logic [SRC_GRP-1:0] tmr_lvl,
   input  logic [SRC_GRP-1:0] mbx_lvl,
   input  logic               gpu_i,
   input  logic               gpu_f,
   input  logic               ltm_i,
   input  logic               ltm_f,
   output logic [PEND_W-1:0]  irq_word,
   output logic [PEND_W-1:0]  fiq_word
);
   dst_e tmr_dst [SRC_GRP];
   dst_e mbx_dst [SRC_GRP];

   for (genvar n = 0; n < SRC_GRP; n++) begin : g_src
      assign tmr_dst[n] = pick_dst(tmr_lvl[n], tmr_ctl[n], tmr_ctl[n+SRC_GRP]);
      assign mbx_dst[n] = pick_dst(mbx_lvl[n], mbx_ctl[n], mbx_ctl[n+SRC_GRP]);
      assign irq_word[BIT_TMR+n] = (tmr_dst[n] == DST_IRQ);
      assign fiq_word[BIT_TMR+n] = (tmr_dst[n] == DST_FIQ);
      assign irq_word[BIT_MBX+n] = (mbx_dst[n] == DST_IRQ);
      assign fiq_word[BIT_MBX+n] = (mbx_dst[n] == DST_FIQ);
   end

   assign irq_word[BIT_GPU]             = gpu_i;
   assign fiq_word[BIT_GPU]             = gpu_f;
   assign irq_word[BIT_LTM-1:BIT_GPU+1] = '0;
   assign fiq_word[BIT_LTM-1:BIT_GPU+1] = '0;
   assign irq_word[BIT_LTM]             = ltm_i;
   assign fiq_word[BIT_LTM]             = ltm_f;
endmodule

// File: rtl/irq_rt_fanout.sv
module irq_rt_fanout
   import irq_rt_pkg::*;
#(
   parameter int NCORES = 4
) (
   input  logic              gpu_irq,
   input  logic              gpu_fiq,
   input  logic              ltm_req,
   input  route_t            route,
   output logic [NCORES-1:0] gpu_i,
   output logic [NCORES-1:0] gpu_f,
   output logic [NCORES-1:0] ltm_i,
   output logic [NCORES-1:0] ltm_f
);
   for (genvar c = 0; c < NCORES; c++) begin : g_core
      localparam logic [1:0] CID = 2'(c);
      logic ltm_here;
      assign ltm_here = ltm_req && (route.ltm_core == CID);
      assign gpu_i[c] = gpu_irq && (route.gpu_irq_core == CID);
      assign gpu_f[c] = gpu_fiq && (route.gpu_fiq_core == CID);
      assign ltm_i[c] = ltm_here && !route.ltm_fiq;
      assign ltm_f[c] = ltm_here && route.ltm_fiq;
   end
endmodule

// File: rtl/irq_rt_outq.sv
module irq_rt_outq
   import irq_rt_pkg::*;
#(
   parameter int NCORES    = 4,
   parameter int OUT_STAGE = 1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NCORES-1:0][PEND_W-1:0] irq_words,
   input  logic [NCORES-1:0][PEND_W-1:0] fiq_words,
   output logic [NCORES-1:0]             core_irq,
   output logic [NCORES-1:0]             core_fiq
);
   logic [NCORES-1:0] irq_any;
   logic [NCORES-1:0] fiq_any;

   for (genvar c = 0; c < NCORES; c++) begin : g_any
      assign irq_any[c] = |irq_words[c];
      assign fiq_any[c] = |fiq_words[c];
   end

   if (OUT_STAGE != 0) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            core_irq <= '0;
            core_fiq <= '0;
         end else begin
            core_irq <= irq_any;
            core_fiq <= fiq_any;
         end
      end
   end else begin : g_wire
      assign core_irq = irq_any;
      assign core_fiq = fiq_any;
   end
endmodule

// File: rtl/irq_rt_regs.sv
module irq_rt_regs
   import irq_rt_pkg::*;
#(
   parameter int NCORES = 4,
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [ADDR_W-1:0]             addr,
   input  logic [DATA_W-1:0]             wdata,
   input  logic [NCORES-1:0][PEND_W-1:0] irq_words,
   input  logic [NCORES-1:0][PEND_W-1:0] fiq_words,
   output logic [NCORES-1:0][CTL_W-1:0]  tmr_ctl,
   output logic [NCORES-1:0][CTL_W-1:0]  mbx_ctl,
   output route_t                        route,
   output logic [DATA_W-1:0]             rdata
);
   logic             hi_zero;
   logic             aligned;
   logic [3:0]       grp;
   logic [1:0]       slot;
   logic             hit_gpu;
   logic             hit_ltm;
   logic [DATA_W-1:0] rd_next;
   logic             unused_wdata;

   if (ADDR_W > 8) begin : g_hi
      assign hi_zero = ~|addr[ADDR_W-1:8];
   end else begin : g_nohi
      assign hi_zero = 1'b1;
   end

   assign aligned = hi_zero && (addr[1:0] == 2'b00);
   assign grp     = addr[7:4];
   assign slot    = addr[3:2];
   assign hit_gpu = aligned && (grp == GRP_GPU) && (slot == SLOT_GPU);
   assign hit_ltm = aligned && (grp == GRP_LTM) && (slot == SLOT_LTM);
   assign unused_wdata = ^wdata[DATA_W-1:CTL_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         route <= '0;
      end else if (wr_en) begin
         if (hit_gpu) begin
            route.gpu_irq_core <= wdata[1:0];
            route.gpu_fiq_core <= wdata[3:2];
         end
         if (hit_ltm) begin
            route.ltm_core <= wdata[1:0];
            route.ltm_fiq  <= wdata[2];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tmr_ctl <= '0;
         mbx_ctl <= '0;
      end else if (wr_en && aligned) begin
         for (int c = 0; c < NCORES; c++) begin
            if (slot == 2'(c)) begin
               if (grp == GRP_TCTL) tmr_ctl[c] <= wdata[CTL_W-1:0];
               if (grp == GRP_MCTL) mbx_ctl[c] <= wdata[CTL_W-1:0];
            end
         end
      end
   end

   always_comb begin
      rd_next = '0;
      if (hit_gpu) begin
         rd_next[3:0] = {route.gpu_fiq_core, route.gpu_irq_core};
      end else if (hit_ltm) begin
         rd_next[2:0] = {route.ltm_fiq, route.ltm_core};
      end else if (aligned) begin
         for (int c = 0; c < NCORES; c++) begin
            if (slot == 2'(c)) begin
               unique case (grp)
                  GRP_TCTL:  rd_next[CTL_W-1:0]  = tmr_ctl[c];
                  GRP_MCTL:  rd_next[CTL_W-1:0]  = mbx_ctl[c];
                  GRP_IPEND: rd_next[PEND_W-1:0] = irq_words[c];
                  GRP_FPEND: rd_next[PEND_W-1:0] = fiq_words[c];
                  default:   rd_next = '0;
               endcase
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rdata <= '0;
      else        rdata <= rd_next;
   end
endmodule

// File: rtl/irq_router.sv
module irq_router
   import irq_rt_pkg::*;
#(
   parameter int NCORES    = 4,
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 32,
   parameter int OUT_STAGE = 1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        reg_wr,
   input  logic [ADDR_W-1:0]           reg_addr,
   input  logic [DATA_W-1:0]           reg_wdata,
   output logic [DATA_W-1:0]           reg_rdata,
   input  logic [NCORES*SRC_GRP-1:0]   tmr_req,
   input  logic [NCORES*SRC_GRP-1:0]   mbx_pend,
   input  logic                        gpu_irq,
   input  logic                        gpu_fiq,
   input  logic                        ltm_req,
   output logic [NCORES-1:0]           core_irq,
   output logic [NCORES-1:0]           core_fiq
);
   if (NCORES < 1 || NCORES > 4) begin : g_bad_cores
      $error("irq_router: NCORES must lie in 1..4");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      $error("irq_router: ADDR_W must be at least 8");
   end
   if (DATA_W < 16) begin : g_bad_data
      $error("irq_router: DATA_W must be at least 16");
   end
   if (OUT_STAGE != 0 && OUT_STAGE != 1) begin : g_bad_stage
      $error("irq_router: OUT_STAGE must be 0 or 1");
   end

   logic [NCORES-1:0][CTL_W-1:0]  tmr_ctl;
   logic [NCORES-1:0][CTL_W-1:0]  mbx_ctl;
   route_t                        route;
   logic [NCORES-1:0][PEND_W-1:0] irq_words;
   logic [NCORES-1:0][PEND_W-1:0] fiq_words;
   logic [NCORES-1:0]             gpu_i, gpu_f, ltm_i, ltm_f;

   irq_rt_regs #(.NCORES(NCORES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (reg_wr),
      .addr      (reg_addr),
      .wdata     (reg_wdata),
      .irq_words (irq_words),
      .fiq_words (fiq_words),
      .tmr_ctl   (tmr_ctl),
      .mbx_ctl   (mbx_ctl),
      .route     (route),
      .rdata     (reg_rdata)
   );

   irq_rt_fanout #(.NCORES(NCORES)) u_fanout (
      .gpu_irq (gpu_irq),
      .gpu_fiq (gpu_fiq),
      .ltm_req (ltm_req),
      .route   (route),
      .gpu_i   (gpu_i),
      .gpu_f   (gpu_f),
      .ltm_i   (ltm_i),
      .ltm_f   (ltm_f)
   );

   for (genvar c = 0; c < NCORES; c++) begin : g_core
      irq_rt_steer u_steer (
         .tmr_ctl  (tmr_ctl[c]),
         .mbx_ctl  (mbx_ctl[c]),
         .tmr_lvl  (tmr_req[c*SRC_GRP +: SRC_GRP]),
         .mbx_lvl  (mbx_pend[c*SRC_GRP +: SRC_GRP]),
         .gpu_i    (gpu_i[c]),
         .gpu_f    (gpu_f[c]),
         .ltm_i    (ltm_i[c]),
         .ltm_f    (ltm_f[c]),
         .irq_word (irq_words[c]),
         .fiq_word (fiq_words[c])
      );
   end

   irq_rt_outq #(.NCORES(NCORES), .OUT_STAGE(OUT_STAGE)) u_outq (
      .clk       (clk),
      .rst_n     (rst_n),
      .irq_words (irq_words),
      .fiq_words (fiq_words),
      .core_irq  (core_irq),
      .core_fiq  (core_fiq)
   );
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk
   import irq_rt_pkg::*;
#(
   parameter int NCORES    = 4,
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 32,
   parameter int OUT_STAGE = 1
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic [ADDR_W-1:0]         reg_addr,
   input logic [DATA_W-1:0]         reg_rdata,
   input logic [NCORES*SRC_GRP-1:0] tmr_req,
   input logic [NCORES*SRC_GRP-1:0] mbx_pend,
   input logic                      gpu_irq,
   input logic                      gpu_fiq,
   input logic                      ltm_req,
   input logic [NCORES-1:0]         core_irq,
   input logic [NCORES-1:0]         core_fiq
);
   logic locals_quiet, all_quiet, gpu_irq_only, ltm_only;
   logic misaligned, ctl_slot, pend_slot;

   assign locals_quiet = (tmr_req == '0) && (mbx_pend == '0);
   assign all_quiet    = locals_quiet && !gpu_irq && !gpu_fiq && !ltm_req;
   assign gpu_irq_only = locals_quiet && gpu_irq && !gpu_fiq && !ltm_req;
   assign ltm_only     = locals_quiet && !gpu_irq && !gpu_fiq && ltm_req;
   assign misaligned   = (reg_addr[1:0] != 2'b00);
   assign ctl_slot     = !misaligned && (reg_addr[7:5] == 3'b010);
   assign pend_slot    = !misaligned && (reg_addr[7:5] == 3'b011);

   if (OUT_STAGE != 0) begin : g_lat1
      AST_QUIET_NO_LINES: assert property (@(posedge clk) disable iff (!rst_n)
         all_quiet |=> (core_irq == '0 && core_fiq == '0)); // R5
      AST_GPU_IRQ_ONE_CORE: assert property (@(posedge clk) disable iff (!rst_n)
         gpu_irq_only |=> ($onehot0(core_irq) && core_fiq == '0)); // R7
      AST_LTM_ONE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
         ltm_only |=> ($countones({core_irq, core_fiq}) <= 1)); // R8
   end else begin : g_lat0
      AST_QUIET_NO_LINES: assert property (@(posedge clk) disable iff (!rst_n)
         all_quiet |-> (core_irq == '0 && core_fiq == '0)); // R5
      AST_GPU_IRQ_ONE_CORE: assert property (@(posedge clk) disable iff (!rst_n)
         gpu_irq_only |-> ($onehot0(core_irq) && core_fiq == '0)); // R7
      AST_LTM_ONE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
         ltm_only |-> ($countones({core_irq, core_fiq}) <= 1)); // R8
   end

   AST_MISALIGNED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      misaligned |=> (reg_rdata == '0)); // R10
   AST_HIGH_GROUP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      reg_addr[7] |=> (reg_rdata == '0)); // R10
   AST_CTL_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_slot |=> (reg_rdata[DATA_W-1:CTL_W] == '0)); // R2
   AST_PEND_GAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      pend_slot |=> (reg_rdata[DATA_W-1:PEND_W] == '0 && reg_rdata[10:9] == 2'b00)); // R9
   AST_GPU_RT_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      (!misaligned && reg_addr[7:2] == 6'h03) |=> (reg_rdata[DATA_W-1:4] == '0)); // R7
   AST_LTM_RT_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      (!misaligned && reg_addr[7:2] == 6'h09) |=> (reg_rdata[DATA_W-1:3] == '0)); // R8
endmodule

bind irq_router irq_router_chk #(
   .NCORES(NCORES), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OUT_STAGE(OUT_STAGE)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_addr  (reg_addr),
   .reg_rdata (reg_rdata),
   .tmr_req   (tmr_req),
   .mbx_pend  (mbx_pend),
   .gpu_irq   (gpu_irq),
   .gpu_fiq   (gpu_fiq),
   .ltm_req   (ltm_req),
   .core_irq  (core_irq),
   .core_fiq  (core_fiq)
);

// File: tb/irq_router_test.sv
`timescale 1ns/100ps
module irq_router_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [15:0] tmr_req = '0;
   logic [15:0] mbx_pend = '0;
   logic        gpu_irq = 1'b0;
   logic        gpu_fiq = 1'b0;
   logic        ltm_req = 1'b0;
   logic [3:0]  core_irq;
   logic [3:0]  core_fiq;

   int total = 0;
   int bad = 0;

   always #2.5 clk = ~clk;

   irq_router uut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tmr_req(tmr_req),
      .mbx_pend(mbx_pend), .gpu_irq(gpu_irq), .gpu_fiq(gpu_fiq),
      .ltm_req(ltm_req), .core_irq(core_irq), .core_fiq(core_fiq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
      reg_addr = a;
      @(negedge clk);
      chk(req, reg_rdata, exp);
   endtask

   task automatic lines_chk(input string req, input logic [3:0] ei, input logic [3:0] ef);
      @(negedge clk);
      chk({req, " irq"}, {28'd0, core_irq}, {28'd0, ei});
      chk({req, " fiq"}, {28'd0, core_fiq}, {28'd0, ef});
   endtask

   task automatic quiesce();
      tmr_req = '0; mbx_pend = '0; gpu_irq = 1'b0; gpu_fiq = 1'b0; ltm_req = 1'b0;
      for (int c = 0; c < 4; c++) begin
         wr(8'h40 + 8'(4*c), 32'h0);
         wr(8'h50 + 8'(4*c), 32'h0);
      end
      wr(8'h0C, 32'h0);
      wr(8'h24, 32'h0);
      @(negedge clk);
   endtask

   task automatic t_reset();
      chk("R1 irq lines", {28'd0, core_irq}, 32'h0);
      chk("R1 fiq lines", {28'd0, core_fiq}, 32'h0);
      rd_chk("R1 gpu route", 8'h0C, 32'h0);
      rd_chk("R1 ltm route", 8'h24, 32'h0);
      rd_chk("R1 tmr ctl core3", 8'h4C, 32'h0);
      rd_chk("R1 mbx ctl core1", 8'h54, 32'h0);
   endtask

   task automatic t_ctl_rw();
      wr(8'h44, 32'hFFFF_A5C3);
      rd_chk("R2 tmr ctl low byte", 8'h44, 32'h0000_00C3);
      wr(8'h58, 32'h1234_5678);
      rd_chk("R2 mbx ctl low byte", 8'h58, 32'h0000_0078);
      quiesce();
   endtask

   task automatic t_timer_irq();
      wr(8'h40, 32'h01);
      @(negedge clk);
      tmr_req[0] = 1'b1;
      #1 chk("R9 line waits for edge", {28'd0, core_irq}, 32'h0);
      lines_chk("R3 core0 timer0", 4'b0001, 4'b0000);
      rd_chk("R3 irq pend core0", 8'h60, 32'h1);
      rd_chk("R3 fiq pend core0", 8'h70, 32'h0);
      wr(8'h48, 32'h08);
      tmr_req[11] = 1'b1;
      lines_chk("R9 core2 timer3 after write", 4'b0101, 4'b0000);
      rd_chk("R3 irq pend core2", 8'h68, 32'h8);
      quiesce();
   endtask

   task automatic t_fiq_priority();
      wr(8'h40, 32'h11);
      tmr_req[0] = 1'b1;
      lines_chk("R4 both enables", 4'b0000, 4'b0001);
      rd_chk("R4 fiq pend core0", 8'h70, 32'h1);
      rd_chk("R4 irq pend core0", 8'h60, 32'h0);
      quiesce();
   endtask

   task automatic t_drop();
      tmr_req = 16'hFFFF;
      mbx_pend = 16'hFFFF;
      lines_chk("R5 no enables", 4'b0000, 4'b0000);
      rd_chk("R5 irq pend core1", 8'h64, 32'h0);
      rd_chk("R5 fiq pend core3", 8'h7C, 32'h0);
      quiesce();
   endtask

   task automatic t_mailbox();
      wr(8'h54, 32'h20);
      mbx_pend[5] = 1'b1;
      wr(8'h5C, 32'h08);
      mbx_pend[15] = 1'b1;
      lines_chk("R6 mailboxes", 4'b1000, 4'b0010);
      rd_chk("R6 fiq pend core1", 8'h74, 32'h20);
      rd_chk("R6 irq pend core3", 8'h6C, 32'h80);
      quiesce();
   endtask

   task automatic t_gpu();
      wr(8'h0C, 32'hFFFF_FFF6);
      rd_chk("R7 gpu route readback", 8'h0C, 32'h6);
      reg_addr = 8'h24;
      #1 chk("R11 rdata holds before edge", reg_rdata, 32'h6);
      @(negedge clk);
      chk("R11 rdata after edge", reg_rdata, 32'h0);
      gpu_irq = 1'b1;
      lines_chk("R7 gpu irq to core2", 4'b0100, 4'b0000);
      gpu_fiq = 1'b1;
      lines_chk("R7 gpu fiq to core1", 4'b0100, 4'b0010);
      rd_chk("R7 irq pend core2", 8'h68, 32'h100);
      rd_chk("R7 fiq pend core1", 8'h74, 32'h100);
      quiesce();
   endtask

   task automatic t_local_timer();
      wr(8'h24, 32'hFFFF_FFFF);
      rd_chk("R8 ltm route 3 bits", 8'h24, 32'h7);
      ltm_req = 1'b1;
      lines_chk("R8 ltm fiq core3", 4'b0000, 4'b1000);
      rd_chk("R8 fiq pend core3", 8'h7C, 32'h800);
      wr(8'h24, 32'h1);
      lines_chk("R8 ltm irq core1", 4'b0010, 4'b0000);
      rd_chk("R8 irq pend core1", 8'h64, 32'h800);
      quiesce();
   endtask

   task automatic t_unmapped();
      wr(8'h40, 32'h0F);
      wr(8'h60, 32'hFFFF_FFFF);
      rd_chk("R10 pend word not writable", 8'h60, 32'h0);
      wr(8'h10, 32'hFF);
      rd_chk("R10 unmapped read", 8'h10, 32'h0);
      wr(8'h41, 32'hAA);
      rd_chk("R10 misaligned write ignored", 8'h40, 32'h0F);
      rd_chk("R10 misaligned read", 8'h42, 32'h0);
      rd_chk("R10 high offset read", 8'hC0, 32'h0);
      chk("R10 lines quiet", {24'd0, core_irq, core_fiq}, 32'h0);
      quiesce();
   endtask

   initial begin
      #(200000 * 5);
      bad++;
      total++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_ctl_rw();
      t_timer_irq();
      t_fiq_priority();
      t_drop();
      t_mailbox();
      t_gpu();
      t_local_timer();
      t_unmapped();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule